// File: doc/BRIEF.md
# Center-Aligned PWM Period Timer

This block is the time base of a three-phase, center-aligned PWM unit. An up/down counter rises through the first half of each PWM period and falls through the second half. Each half lasts a number of ticks set by a programmable period value, so a full period is twice that value. A sync pulse of programmable width marks the start of every period, and a half-cycle flag shows which half is running. Single-cycle strobes mark the first tick of each half.

Software writes the period, sync width, dead time, three duty values and an update-mode bit through a plain write port (enable, address, data). The writes land in shadow registers. The shadow values move into the active set that downstream comparators and dead-time logic read. In single update mode this happens only at the period boundary, so both halves use the same values and the waveform is symmetric about the period center. In double update mode it also happens at mid-period, so the second half may use different values. The block exports the count, the half flag, the strobes and the active values. It does not generate the switch outputs.

Top module: `pwm_period_timer`

## Requirements
- R1: With active period value P, the first half counts 0, 1, ..., P-1 and the second half counts P, P-1, ..., 1, after which the count returns to 0. Each half therefore lasts P ticks.
- R2: `half_o` is 0 during the first (rising) half and 1 during the second (falling) half.
- R3: `sync_o` goes high on the first tick of each period and stays high for W+1 ticks, where W is the active sync width. A new period start restarts the pulse.
- R4: After reset, count=0, `half_o`=0, the first period starts at once, and the active values are: period 100, sync width 39 (a 40-tick pulse), dead time 8, each duty 50, single update mode.
- R5: In single update mode, the active values change only on the first tick of a period, and they take the shadow contents that were present one cycle earlier.
- R6: In double update mode, the active period, sync width, dead time and duty values are also loaded from the shadow registers on the first tick of the second half. The second half then counts down from the newly loaded period.
- R7: The update-mode bit (address 3, data bit 0, 1 = double) becomes active only at a period boundary, never at mid-period.
- R8: Writing 0 to the period address stores 1.
- R9: `start_o` is high only on the first tick of a period (count 0, first half). `mid_o` is high only on the first tick of the second half. Each strobe lasts one tick.
- R10: Write addresses are 0 period, 1 sync width, 2 dead time, 3 mode, and 4+k for the duty of phase k (k = 0..2). A write to address 7 changes nothing.
- R11: A write made in the same cycle as a reload edge is not copied by that reload. It stays in the shadow register and takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the shadow registers |
| wr_addr | input | 3 | Shadow register address |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Up/down count |
| half_o | output | 1 | 0 = first half, 1 = second half |
| sync_o | output | 1 | Period sync pulse |
| start_o | output | 1 | First tick of a period |
| mid_o | output | 1 | First tick of the second half |
| period_o | output | 16 | Active half-period value |
| dead_o | output | 10 | Active dead-time value |
| duty_o | output | 48 | Active duties, phase k at bits [16k+15:16k] |

## Verification
The case that needs care is a register write that falls in the same cycle as a reload edge, that is, the last tick of either half. Whether that write is copied decides what the next half sees. The random stimulus watches its own model of the count and raises the write probability to one half on those exact cycles. It uses short periods of 1 to 12 ticks and flips the update mode often, so that mid-period and period-end reloads both collide with writes many times. A cycle-level reference model, built from the requirements, predicts the count, flag, sync, strobes and active values, and every one of them is compared at every tick.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int SW_W   = 8;
    localparam int DT_W   = 10;
    localparam int DUTY_W = 16;
    localparam int NUM_PH = 3;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;

    localparam int ADR_PERIOD = 0;
    localparam int ADR_SYNC   = 1;
    localparam int ADR_DEAD   = 2;
    localparam int ADR_MODE   = 3;
    localparam int ADR_DUTY0  = 4;

    typedef struct packed {
        logic                           dbl;
        logic [CNT_W-1:0]               period;
        logic [SW_W-1:0]                sync_w;
        logic [DT_W-1:0]                dead;
        logic [NUM_PH-1:0][DUTY_W-1:0]  duty;
    } pwm_cfg_t;

    typedef struct packed {
        pwm_cfg_t sh;
        pwm_cfg_t act;
    } cfg_bank_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             half;
        logic             start;
        logic             mid;
    } ctr_state_t;
endpackage

// File: rtl/pwm_cfg_bank.sv
module pwm_cfg_bank
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned DEF_PERIOD = 100,
    parameter int unsigned DEF_SYNC   = 39,
    parameter int unsigned DEF_DEAD   = 8,
    parameter int unsigned DEF_DUTY   = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_end_i,
    input  logic              load_mid_i,
    output pwm_cfg_t          act_o,
    output pwm_cfg_t          act_next_o
);
    cfg_bank_t st_d, st_q;

    function automatic pwm_cfg_t def_cfg();
        pwm_cfg_t c;
        c.dbl    = 1'b0;
        c.period = CNT_W'(DEF_PERIOD);
        c.sync_w = SW_W'(DEF_SYNC);
        c.dead   = DT_W'(DEF_DEAD);
        for (int k = 0; k < NUM_PH; k++) begin
            c.duty[k] = DUTY_W'(DEF_DUTY);
        end
        return c;
    endfunction

    always_comb begin
        st_d = st_q;
        // reload uses the shadow contents before this cycle's write (R11)
        if (load_end_i) begin
            st_d.act = st_q.sh;
        end else if (load_mid_i && st_q.act.dbl) begin
            st_d.act     = st_q.sh;
            st_d.act.dbl = st_q.act.dbl;
        end
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_PERIOD)) begin
                st_d.sh.period = (wr_data[CNT_W-1:0] == '0) ? CNT_W'(1)
                                                             : wr_data[CNT_W-1:0];
            end
            if (wr_addr == ADDR_W'(ADR_SYNC)) st_d.sh.sync_w = wr_data[SW_W-1:0];
            if (wr_addr == ADDR_W'(ADR_DEAD)) st_d.sh.dead   = wr_data[DT_W-1:0];
            if (wr_addr == ADDR_W'(ADR_MODE)) st_d.sh.dbl    = wr_data[0];
            for (int k = 0; k < NUM_PH; k++) begin
                if (wr_addr == ADDR_W'(ADR_DUTY0 + k)) begin
                    st_d.sh.duty[k] = wr_data[DUTY_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= def_cfg();
            st_q.act <= def_cfg();
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o      = st_q.act;
    assign act_next_o = st_d.act;

    // R8: a zero period never reaches shadow or active state
    a_r8_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sh.period != '0 && st_q.act.period != '0);

    // R7: the mode bit only moves into the active set at a period boundary
    a_r7_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !load_end_i |=> $stable(st_q.act.dbl));

    // R5: without a reload edge the active period stays put
    a_r5_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_end_i && !load_mid_i) |=> $stable(st_q.act));
endmodule

// File: rtl/pwm_updown_ctr.sv
module pwm_updown_ctr
    import pwm_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] per_next_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             half_o,
    output logic             start_o,
    output logic             mid_o,
    output logic             turn_mid_o,
    output logic             turn_end_o
);
    ctr_state_t st_d, st_q;
    logic       turn_mid, turn_end;

    always_comb begin
        turn_mid = !st_q.half && (st_q.cnt == per_i - CNT_W'(1));
        turn_end =  st_q.half && (st_q.cnt == CNT_W'(1));
        st_d       = st_q;
        st_d.start = turn_end;
        st_d.mid   = turn_mid;
        if (turn_mid) begin
            st_d.cnt  = per_next_i;
            st_d.half = 1'b1;
        end else if (turn_end) begin
            st_d.cnt  = '0;
            st_d.half = 1'b0;
        end else if (st_q.half) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.half  <= 1'b0;
            st_q.start <= 1'b1;
            st_q.mid   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o      = st_q.cnt;
    assign half_o     = st_q.half;
    assign start_o    = st_q.start;
    assign mid_o      = st_q.mid;
    assign turn_mid_o = turn_mid;
    assign turn_end_o = turn_end;

    a_r1_rise_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.half |-> st_q.cnt < per_i);

    a_r1_fall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.half |-> (st_q.cnt <= per_i && st_q.cnt != '0));

    a_r2_half_flips_on_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_mid || turn_end) |=> (st_q.half != $past(st_q.half)));

    a_r9_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |-> (st_q.cnt == '0 && !st_q.half));

    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.start && st_q.mid));
endmodule

// File: rtl/pwm_sync_pulse.sv
module pwm_sync_pulse
    import pwm_tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [SW_W-1:0] width_i,
    output logic            sync_o
);
    logic [SW_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (start_i) begin
            rem_d = width_i;
        end else if (rem_q != '0) begin
            rem_d = rem_q - SW_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign sync_o = start_i || (rem_q != '0);

    a_r3_high_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> sync_o);

    a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q != '0 && !start_i) |=> rem_q == $past(rem_q) - SW_W'(1));
endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned DEF_PERIOD = 100,
    parameter int unsigned DEF_SYNC   = 39,
    parameter int unsigned DEF_DEAD   = 8,
    parameter int unsigned DEF_DUTY   = 50
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [CNT_W-1:0]         cnt_o,
    output logic                     half_o,
    output logic                     sync_o,
    output logic                     start_o,
    output logic                     mid_o,
    output logic [CNT_W-1:0]         period_o,
    output logic [DT_W-1:0]          dead_o,
    output logic [NUM_PH*DUTY_W-1:0] duty_o
);
    pwm_cfg_t act, act_next;
    logic     turn_mid, turn_end;

    pwm_cfg_bank #(
        .DEF_PERIOD(DEF_PERIOD),
        .DEF_SYNC  (DEF_SYNC),
        .DEF_DEAD  (DEF_DEAD),
        .DEF_DUTY  (DEF_DUTY)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load_end_i(turn_end),
        .load_mid_i(turn_mid),
        .act_o     (act),
        .act_next_o(act_next)
    );

    pwm_updown_ctr ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_i     (act.period),
        .per_next_i(act_next.period),
        .cnt_o     (cnt_o),
        .half_o    (half_o),
        .start_o   (start_o),
        .mid_o     (mid_o),
        .turn_mid_o(turn_mid),
        .turn_end_o(turn_end)
    );

    pwm_sync_pulse sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_o),
        .width_i(act.sync_w),
        .sync_o (sync_o)
    );

    assign period_o = act.period;
    assign dead_o   = act.dead;

    for (genvar k = 0; k < NUM_PH; k++) begin : g_duty
        assign duty_o[k*DUTY_W +: DUTY_W] = act.duty[k];
    end

    // R6: in double update mode the second half begins at the reloaded period
    a_r6_mid_starts_at_period: assert property (@(posedge clk) disable iff (!rst_n)
        mid_o |-> (cnt_o == period_o && half_o));
endmodule

// File: tb/pwm_period_timer_tb_top.sv
module pwm_period_timer_tb_top;
    import pwm_tmr_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     wr_en = 1'b0;
    logic [ADDR_W-1:0]        wr_addr = '0;
    logic [DATA_W-1:0]        wr_data = '0;
    logic [CNT_W-1:0]         cnt_o;
    logic                     half_o, sync_o, start_o, mid_o;
    logic [CNT_W-1:0]         period_o;
    logic [DT_W-1:0]          dead_o;
    logic [NUM_PH*DUTY_W-1:0] duty_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    pwm_cfg_t         m_sh, m_act;
    logic [CNT_W-1:0] m_cnt;
    logic             m_half, m_start, m_mid;
    logic [SW_W-1:0]  m_rem;

    always #4 clk = ~clk;

    pwm_period_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_o(cnt_o), .half_o(half_o), .sync_o(sync_o),
        .start_o(start_o), .mid_o(mid_o), .period_o(period_o),
        .dead_o(dead_o), .duty_o(duty_o)
    );

    function automatic pwm_cfg_t reset_cfg();
        pwm_cfg_t c;
        c.dbl = 1'b0; c.period = 16'd100; c.sync_w = 8'd39; c.dead = 10'd8;
        for (int k = 0; k < NUM_PH; k++) c.duty[k] = 16'd50;
        return c;
    endfunction

    function automatic logic exp_sync();
        return m_start || (m_rem != '0);
    endfunction

    function automatic logic reload_edge_next();
        return (m_half && m_cnt == 16'd1) ||
               (!m_half && m_cnt == m_act.period - 16'd1);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string rq;
        check("R1 count", 64'(cnt_o), 64'(m_cnt));
        check("R2 half flag", 64'(half_o), 64'(m_half));
        check("R3 sync", 64'(sync_o), 64'(exp_sync()));
        check("R9 start strobe", 64'(start_o), 64'(m_start));
        check("R9 mid strobe", 64'(mid_o), 64'(m_mid));
        rq = m_act.dbl ? "R6 R7 R11 active" : "R5 R7 R11 active";
        check({rq, " period"}, 64'(period_o), 64'(m_act.period));
        check({rq, " dead"}, 64'(dead_o), 64'(m_act.dead));
        for (int k = 0; k < NUM_PH; k++) begin
            check({rq, " duty"}, 64'(duty_o[k*DUTY_W +: DUTY_W]), 64'(m_act.duty[k]));
        end
    endtask

    task automatic model_step(input logic we, input logic [ADDR_W-1:0] a,
                              input logic [DATA_W-1:0] d);
        logic     t_mid, t_end;
        pwm_cfg_t nact;
        t_mid = !m_half && (m_cnt == m_act.period - 16'd1);
        t_end =  m_half && (m_cnt == 16'd1);
        nact = m_act;
        if (t_end) nact = m_sh;
        else if (t_mid && m_act.dbl) begin
            nact = m_sh;
            nact.dbl = m_act.dbl;
        end
        if (m_start) m_rem = m_act.sync_w;
        else if (m_rem != '0) m_rem = m_rem - 8'd1;
        if (t_mid) begin m_cnt = nact.period; m_half = 1'b1; end
        else if (t_end) begin m_cnt = '0; m_half = 1'b0; end
        else if (m_half) m_cnt = m_cnt - 16'd1;
        else m_cnt = m_cnt + 16'd1;
        m_start = t_end;
        m_mid   = t_mid;
        m_act   = nact;
        if (we) begin
            case (a)
                3'd0: m_sh.period = (d == 16'd0) ? 16'd1 : d;
                3'd1: m_sh.sync_w = d[7:0];
                3'd2: m_sh.dead   = d[9:0];
                3'd3: m_sh.dbl    = d[0];
                3'd4: m_sh.duty[0] = d;
                3'd5: m_sh.duty[1] = d;
                3'd6: m_sh.duty[2] = d;
                default: ;
            endcase
        end
    endtask

    task automatic tick(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        check_all();
        wr_en = we; wr_addr = a; wr_data = d;
        model_step(we, a, d);
        @(negedge clk);
    endtask

    task automatic run_idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0, '0);
    endtask

    task automatic run_to_start();
        for (int i = 0; i < 1000; i++) begin
            if (m_start) break;
            tick(1'b0, '0, '0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_sh = reset_cfg(); m_act = reset_cfg();
        m_cnt = '0; m_half = 1'b0; m_start = 1'b1; m_mid = 1'b0; m_rem = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4: reset state seen before the first active edge
        check("R4 reset count", 64'(cnt_o), 64'd0);
        check("R4 reset sync", 64'(sync_o), 64'd1);
        check("R4 reset period", 64'(period_o), 64'd100);
        check("R4 reset dead", 64'(dead_o), 64'd8);
        // R4: default 40-tick sync pulse
        run_idle(39);
        check("R4 sync tick 39", 64'(sync_o), 64'd1);
        run_idle(1);
        check("R4 sync tick 40", 64'(sync_o), 64'd0);
        // R8: zero period becomes 1; R10: address 7 ignored
        tick(1'b1, 3'd0, 16'd0);
        tick(1'b1, 3'd7, 16'hFFFF);
        tick(1'b1, 3'd1, 16'd2);
        run_idle(170);
        run_to_start();
        check("R8 period after zero write", 64'(period_o), 64'd1);
        check("R10 dead unchanged by addr 7", 64'(dead_o), 64'd8);
        run_idle(8);
        // R6 R7: double mode takes effect at boundary only
        tick(1'b1, 3'd0, 16'd5);
        run_to_start();
        tick(1'b1, 3'd3, 16'd1);
        run_to_start();
        tick(1'b1, 3'd0, 16'd3);
        run_idle(30);
        // constrained random phase
        for (int i = 0; i < 8000; i++) begin
            logic            we;
            logic [2:0]      a;
            logic [15:0]     d;
            we = reload_edge_next() ? ($urandom_range(1) == 1) : ($urandom_range(5) == 0);
            a  = 3'($urandom_range(7));
            case (a)
                3'd0: d = 16'($urandom_range(12));
                3'd1: d = 16'($urandom_range(15));
                3'd3: d = 16'($urandom_range(1));
                default: d = 16'($urandom);
            endcase
            tick(we, a, d);
        end
        check_all();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule